// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the control and status flags of endpoint zero in a USB device controller. One side is a CPU register port with a single-cycle write strobe and a combinational read of the status byte and the FIFO byte count. The other side is a packet-level event interface that reports the following:
- a received byte;
- a completed OUT or SETUP packet;
- a host acknowledge of a transmitted IN packet;
- a transmitted STALL handshake;
- the end of a control transaction.

The 64-byte endpoint-zero FIFO is modelled only as a fill counter. It is filled by received bytes or by CPU loads and drained by CPU reads.

The block raises a one-cycle interrupt pulse for each reportable event and asks the packet side for STALL responses while software holds the stall request bit. When a control transaction ends before software has marked the last data packet, the block records an abort, flushes the FIFO and interrupts. Software must clear that abort with a dedicated write-one service bit.

Status byte layout, shared by reads and writes:
- bit0: OUT packet held;
- bit1: IN packet armed;
- bit2: STALL sent;
- bit3: last packet marked;
- bit4: early end seen;
- bit5: stall request;
- bit6: service OUT, write-one;
- bit7: service early end, write-one.

Top module: `ep0_ctrl_csr`

## Requirements
- R1: After reset, every status bit reads 0, the byte count is 0, and `irq`, `fifo_flush` and `stall_req` are low.
- R2: Each cycle the byte count moves by (`pkt_rx_byte` + `cpu_fifo_wr` − `cpu_fifo_rd`), clamped to the range 0..64, where 64 is the endpoint-zero maximum packet size.
- R3: `pkt_rx_done` sets bit0 and pulses `irq`. A CPU write with bit6 = 1 clears bit0 and zeroes the byte count.
- R4: A CPU write with bit1 = 1 sets bit1, and a write with bit1 = 0 leaves it unchanged. While bit1 is set, `pkt_in_ack` clears it, zeroes the count and pulses `irq`. When bit1 is clear, `pkt_in_ack` is ignored and no pulse occurs.
- R5: A CPU write with bit3 = 1 sets bit3, in the same write as bit1 if desired. `pkt_xfer_end` while bit3 is set clears bit3, sets no abort and raises no interrupt.
- R6: `pkt_xfer_end` while bit3 is clear has the following effects:
  - it sets bit4;
  - it clears bits 0 and 1;
  - it zeroes the count;
  - it drives `fifo_flush` high for exactly one cycle;
  - it pulses `irq`.
- R7: Bit4 is cleared only by a CPU write with bit7 = 1. Writing bit4 itself has no effect.
- R8: `pkt_stall_sent` sets bit2 and pulses `irq`. A CPU write with bit2 = 0 clears bit2, and a write with bit2 = 1 leaves it unchanged.
- R9: Every CPU write loads bit5 from the written value. Bit5 reads back and drives `stall_req`.
- R10: Bits 6 and 7 always read as 0.
- R11: Every event appears on the outputs in the cycle after it is presented. Each event cycle yields exactly one single-cycle `irq` pulse, even when several events coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the status byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_fifo_wr | input | 1 | CPU loads one byte into the FIFO |
| cpu_fifo_rd | input | 1 | CPU reads one byte from the FIFO |
| csr_rdata | output | 8 | Status byte read value |
| byte_count | output | CNT_W | FIFO byte count |
| pkt_rx_byte | input | 1 | One byte received from the host |
| pkt_rx_done | input | 1 | Received packet complete |
| pkt_in_ack | input | 1 | Host acknowledged the transmitted IN packet |
| pkt_stall_sent | input | 1 | STALL handshake transmitted |
| pkt_xfer_end | input | 1 | Control transaction ended |
| stall_req | output | 1 | Request STALL responses |
| fifo_flush | output | 1 | One-cycle FIFO flush strobe |
| irq | output | 1 | Endpoint-zero interrupt pulse |

## Verification
The bench drives the corner cases below and compares every output against a behavioural model on every cycle. A transaction ending while the last-packet mark is still clear must flush and interrupt exactly once. A design that swapped the mark test would flush on normal completions. The bench writes the early-end bit itself and sends an acknowledge with nothing armed. A design that cleared the abort flag on a plain write, or that interrupted on a stale acknowledge, would show the wrong flag or an extra pulse. It also pushes 70 bytes into the 64-byte counter and fires two events in one cycle, exposing wraparound and doubled interrupt pulses.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int B_OUT  = 0;
  localparam int B_IN   = 1;
  localparam int B_SNT  = 2;
  localparam int B_LAST = 3;
  localparam int B_EARL = 4;
  localparam int B_STL  = 5;
  localparam int B_SVO  = 6;
  localparam int B_SVE  = 7;

  // net fill change clamped to the legal FIFO window
  function automatic int clamp_level(int cur, int add, int sub, int maxv);
    int t;
    t = cur + add - sub;
    if (t < 0) t = 0;
    if (t > maxv) t = maxv;
    return t;
  endfunction
endpackage

// File: rtl/ep0_byte_counter.sv
module ep0_byte_counter #(
  parameter int MAXP  = 64,
  parameter int CNT_W = $clog2(MAXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       add,
  input  logic             sub,
  input  logic             clr,
  output logic [CNT_W-1:0] level
);
  import ep0_csr_pkg::*;

  logic [CNT_W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   level_q <= '0;
    else if (clr) level_q <= '0;
    else          level_q <= CNT_W'(clamp_level(int'(level_q), int'(add), int'(sub), MAXP));
  end

  assign level = level_q;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_q) <= MAXP);
endmodule

// File: rtl/ep0_irq_pulse.sv
module ep0_irq_pulse #(
  parameter int N_EV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev,
  output logic            irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |ev;
  end

  assign irq = irq_q;

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|ev));
endmodule

// File: rtl/ep0_ctrl_csr.sv
module ep0_ctrl_csr #(
  parameter int MAXP  = 64,
  parameter int CNT_W = $clog2(MAXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  input  logic             cpu_fifo_wr,
  input  logic             cpu_fifo_rd,
  output logic [7:0]       csr_rdata,
  output logic [CNT_W-1:0] byte_count,
  input  logic             pkt_rx_byte,
  input  logic             pkt_rx_done,
  input  logic             pkt_in_ack,
  input  logic             pkt_stall_sent,
  input  logic             pkt_xfer_end,
  output logic             stall_req,
  output logic             fifo_flush,
  output logic             irq
);
  import ep0_csr_pkg::*;

  localparam int N_EV = 4;

  logic out_rdy, in_rdy, sent_stl, last_pkt, early_end, stl_req, flush_q;

  // named internal events
  logic ev_rx, ev_ack, ev_stall, ev_abort, ev_done;
  logic wr_arm, wr_last, wr_clr_snt, wr_svc_out, wr_svc_end;
  logic cnt_clr;
  logic [1:0] cnt_add;

  assign ev_rx    = pkt_rx_done;
  assign ev_ack   = pkt_in_ack & in_rdy;
  assign ev_stall = pkt_stall_sent;
  assign ev_abort = pkt_xfer_end & ~last_pkt;
  assign ev_done  = pkt_xfer_end & last_pkt;

  assign wr_arm     = cpu_wr & cpu_wdata[B_IN];
  assign wr_last    = cpu_wr & cpu_wdata[B_LAST];
  assign wr_clr_snt = cpu_wr & ~cpu_wdata[B_SNT];
  assign wr_svc_out = cpu_wr & cpu_wdata[B_SVO];
  assign wr_svc_end = cpu_wr & cpu_wdata[B_SVE];

  assign cnt_clr = ev_abort | ev_ack | wr_svc_out;
  assign cnt_add = {1'b0, pkt_rx_byte} + {1'b0, cpu_fifo_wr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_rdy   <= 1'b0;
      in_rdy    <= 1'b0;
      sent_stl  <= 1'b0;
      last_pkt  <= 1'b0;
      early_end <= 1'b0;
      stl_req   <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      if (ev_rx)                      out_rdy <= 1'b1;
      else if (ev_abort | wr_svc_out) out_rdy <= 1'b0;

      if (wr_arm)                 in_rdy <= 1'b1;
      else if (ev_ack | ev_abort) in_rdy <= 1'b0;

      if (pkt_xfer_end) last_pkt <= 1'b0;
      else if (wr_last) last_pkt <= 1'b1;

      if (ev_abort)        early_end <= 1'b1;
      else if (wr_svc_end) early_end <= 1'b0;

      if (ev_stall)        sent_stl <= 1'b1;
      else if (wr_clr_snt) sent_stl <= 1'b0;

      if (cpu_wr) stl_req <= cpu_wdata[B_STL];

      flush_q <= ev_abort;
    end
  end

  ep0_byte_counter #(.MAXP(MAXP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .add(cnt_add), .sub(cpu_fifo_rd),
    .clr(cnt_clr), .level(byte_count)
  );

  ep0_irq_pulse #(.N_EV(N_EV)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev({ev_abort, ev_stall, ev_ack, ev_rx}), .irq(irq)
  );

  always_comb begin
    csr_rdata         = 8'h00;
    csr_rdata[B_OUT]  = out_rdy;
    csr_rdata[B_IN]   = in_rdy;
    csr_rdata[B_SNT]  = sent_stl;
    csr_rdata[B_LAST] = last_pkt;
    csr_rdata[B_EARL] = early_end;
    csr_rdata[B_STL]  = stl_req;
  end

  assign stall_req  = stl_req;
  assign fifo_flush = flush_q;

  assert_abort_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_end) |-> (fifo_flush && byte_count == '0 && irq));

  assert_early_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (early_end && !(cpu_wr && cpu_wdata[B_SVE]) && (cpu_wr || !cpu_wdata[B_EARL]))
      |=> early_end);

  assert_stall_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_stall_sent |=> (csr_rdata[B_SNT] && irq));

  assert_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_in_ack && in_rdy && !wr_arm) |=> (!csr_rdata[B_IN] && irq));

  assert_flush_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush || $past(pkt_xfer_end));
endmodule

// File: tb/test_ep0_ctrl_csr.sv
`timescale 1ns/1ps
module test_ep0_ctrl_csr;
  localparam int MAXP = 64;
  localparam int CW   = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, cpu_fifo_wr = 0, cpu_fifo_rd = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic pkt_rx_byte = 0, pkt_rx_done = 0, pkt_in_ack = 0, pkt_stall_sent = 0, pkt_xfer_end = 0;
  logic [7:0] csr_rdata;
  logic [CW-1:0] byte_count;
  logic stall_req, fifo_flush, irq;

  int compared = 0, mismatched = 0;
  int irq_seen = 0, flush_seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ep0_ctrl_csr #(.MAXP(MAXP)) i_ep0_ctrl_csr (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_fifo_wr(cpu_fifo_wr), .cpu_fifo_rd(cpu_fifo_rd),
    .csr_rdata(csr_rdata), .byte_count(byte_count),
    .pkt_rx_byte(pkt_rx_byte), .pkt_rx_done(pkt_rx_done), .pkt_in_ack(pkt_in_ack),
    .pkt_stall_sent(pkt_stall_sent), .pkt_xfer_end(pkt_xfer_end),
    .stall_req(stall_req), .fifo_flush(fifo_flush), .irq(irq)
  );

  // behavioural reference model
  int  m_cnt;
  bit  m_out, m_in, m_snt, m_last, m_early, m_stl, m_irq, m_flush;
  bit  o_in, o_last, abort, clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_out = 0; m_in = 0; m_snt = 0; m_last = 0;
      m_early = 0; m_stl = 0; m_irq = 0; m_flush = 0;
    end else begin
      o_in = m_in; o_last = m_last;
      abort = pkt_xfer_end && !o_last;
      clr = 0; m_irq = 0; m_flush = abort;
      if (pkt_rx_done) m_irq = 1;
      if (pkt_stall_sent) m_irq = 1;
      if (pkt_in_ack && o_in) begin m_irq = 1; clr = 1; end
      if (abort) begin m_irq = 1; clr = 1; end
      if (cpu_wr && cpu_wdata[6]) clr = 1;
      if (pkt_rx_done) m_out = 1;
      else if (abort || (cpu_wr && cpu_wdata[6])) m_out = 0;
      if (cpu_wr && cpu_wdata[1]) m_in = 1;
      else if ((pkt_in_ack && o_in) || abort) m_in = 0;
      if (pkt_xfer_end) m_last = 0;
      else if (cpu_wr && cpu_wdata[3]) m_last = 1;
      if (abort) m_early = 1;
      else if (cpu_wr && cpu_wdata[7]) m_early = 0;
      if (pkt_stall_sent) m_snt = 1;
      else if (cpu_wr && !cpu_wdata[2]) m_snt = 0;
      if (cpu_wr) m_stl = cpu_wdata[5];
      if (clr) m_cnt = 0;
      else begin
        m_cnt = m_cnt + int'(pkt_rx_byte) + int'(cpu_fifo_wr) - int'(cpu_fifo_rd);
        if (m_cnt < 0) m_cnt = 0;
        if (m_cnt > MAXP) m_cnt = MAXP;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e;
    string tg [8];
    tg = '{"R3 out", "R4 in", "R8 sent", "R5 last", "R6 R7 early", "R9 stall", "R10 svc6", "R10 svc7"};
    e = {2'b00, m_stl, m_early, m_last, m_snt, m_in, m_out};
    for (int b = 0; b < 8; b++) chk(tg[b], int'(csr_rdata[b]), int'(e[b]));
    chk("R2 count", int'(byte_count), m_cnt);
    chk("R11 irq", int'(irq), int'(m_irq));
    chk("R6 flush", int'(fifo_flush), int'(m_flush));
    chk("R9 stall_req", int'(stall_req), int'(m_stl));
    if (irq) irq_seen++;
    if (fifo_flush) flush_seen++;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    cpu_wr = 0; cpu_wdata = 8'h00; cpu_fifo_wr = 0; cpu_fifo_rd = 0;
    pkt_rx_byte = 0; pkt_rx_done = 0; pkt_in_ack = 0; pkt_stall_sent = 0; pkt_xfer_end = 0;
  endtask

  task automatic wr(logic [7:0] v);
    cpu_wr = 1; cpu_wdata = v; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 csr", int'(csr_rdata), 0);
    chk("R1 count", int'(byte_count), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 flush", int'(fifo_flush), 0);
    chk("R1 stall_req", int'(stall_req), 0);

    // R3: SETUP packet received
    irq_seen = 0;
    for (int i = 0; i < 8; i++) begin pkt_rx_byte = 1; tick(); end
    pkt_rx_done = 1; tick();
    chk("R3 out set", int'(csr_rdata[0]), 1);
    chk("R2 count 8", int'(byte_count), 8);
    tick();
    chk("R11 one pulse rx", irq_seen, 1);
    cpu_fifo_rd = 1; tick();
    cpu_fifo_rd = 1; tick();
    chk("R2 count 6", int'(byte_count), 6);
    wr(8'h40);
    chk("R3 out clear", int'(csr_rdata[0]), 0);
    chk("R3 count zero", int'(byte_count), 0);
    chk("R10 bit6 zero", int'(csr_rdata[6]), 0);
    cpu_fifo_rd = 1; tick();
    chk("R2 floor", int'(byte_count), 0);

    // R2 saturation and R4 arming
    for (int i = 0; i < 70; i++) begin cpu_fifo_wr = 1; pkt_rx_byte = (i % 3 == 0); tick(); end
    chk("R2 saturate", int'(byte_count), 64);
    wr(8'h02);
    chk("R4 armed", int'(csr_rdata[1]), 1);
    wr(8'h00);
    chk("R4 write0 keeps", int'(csr_rdata[1]), 1);
    irq_seen = 0;
    pkt_in_ack = 1; tick();
    chk("R4 ack clears", int'(csr_rdata[1]), 0);
    chk("R4 ack count", int'(byte_count), 0);
    pkt_in_ack = 1; tick();
    tick();
    chk("R4 stale ack one pulse", irq_seen, 1);

    // R5 final packet then normal end
    for (int i = 0; i < 3; i++) begin cpu_fifo_wr = 1; tick(); end
    wr(8'h0A);
    chk("R5 last set", int'(csr_rdata[3]), 1);
    pkt_in_ack = 1; tick();
    irq_seen = 0; flush_seen = 0;
    pkt_xfer_end = 1; tick();
    tick();
    chk("R5 last clear", int'(csr_rdata[3]), 0);
    chk("R5 no early", int'(csr_rdata[4]), 0);
    chk("R5 no irq", irq_seen, 0);
    chk("R5 no flush", flush_seen, 0);

    // R6 premature end
    for (int i = 0; i < 5; i++) begin cpu_fifo_wr = 1; tick(); end
    wr(8'h02);
    irq_seen = 0; flush_seen = 0;
    pkt_xfer_end = 1; tick();
    chk("R6 early set", int'(csr_rdata[4]), 1);
    chk("R6 in cleared", int'(csr_rdata[1]), 0);
    chk("R6 count zero", int'(byte_count), 0);
    tick(); tick();
    chk("R6 one flush", flush_seen, 1);
    chk("R6 one irq", irq_seen, 1);
    wr(8'h10);
    chk("R7 write bit4 no effect", int'(csr_rdata[4]), 1);
    wr(8'h00);
    chk("R7 write0 no effect", int'(csr_rdata[4]), 1);
    wr(8'h80);
    chk("R7 svc clears", int'(csr_rdata[4]), 0);
    chk("R10 bit7 zero", int'(csr_rdata[7]), 0);

    // R8 / R9 stall
    wr(8'h20);
    chk("R9 stall_req", int'(stall_req), 1);
    chk("R9 readback", int'(csr_rdata[5]), 1);
    irq_seen = 0;
    pkt_stall_sent = 1; tick();
    chk("R8 sent set", int'(csr_rdata[2]), 1);
    wr(8'h24);
    chk("R8 write1 keeps", int'(csr_rdata[2]), 1);
    chk("R8 one irq", irq_seen, 1);
    wr(8'h20);
    chk("R8 write0 clears", int'(csr_rdata[2]), 0);
    chk("R9 still stalled", int'(stall_req), 1);
    wr(8'h00);
    chk("R9 released", int'(stall_req), 0);

    // R11 coincident events
    irq_seen = 0;
    pkt_rx_done = 1; pkt_stall_sent = 1; tick();
    tick(); tick();
    chk("R11 single pulse coincident", irq_seen, 1);
    wr(8'h40);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule